// File: doc/BRIEF.md
# Digital DLL Delay-Code Controller

This block is the digital half of a delay-locked loop. A replica chain of identical delay buffers is tuned until it delays the reference clock by exactly one period. A phase comparator outside the block compares the reference clock with the delayed clock once per cycle. It reports whether more delay or less delay is needed. The controller turns that stream of decisions into a saturating up/down delay code. It detects when the code has settled, and it raises a timeout flag if settling takes too long.

Two offset channels derive shifted codes from the main code. A channel is either fixed at build time, with a signed constant, or driven at run time by a magnitude input and an add/subtract select. Every shifted code is clamped to the ceiling of the selected frequency mode. Once the loop has settled, a periodic one-cycle update strobe tells downstream delay-setting latches to take the current code. The block also models those latches. An asynchronous load input restarts the search from a mode-dependent starting code. The block reports the phase step of one buffer, in degrees, for the chain length it was built with.

Top module: `dll_code_ctrl`

## Requirements
- R1: A synchronous active-low reset sets the delay code and the held code to the start code (16 in low-frequency mode, 32 in high-frequency mode), and clears lock, timeout and the update strobe.
- R2: While `load_i` is high, the delay code equals the start code and lock is low, without waiting for a clock edge. Run, lock and timeout state restart from zero, and the held code is left untouched.
- R3: On an accepted step, `ph_up_i`=1 raises the delay code by one and `ph_up_i`=0 lowers it by one, saturating at 0 and 63. Without jitter reduction, every cycle's sample is an accepted step.
- R4: With jitter reduction, a step is accepted only on the 4th consecutive sample of the same direction. The run then restarts, and a change of direction starts a new run of length 1.
- R5: Lock rises on the accepted step that completes 8 consecutive direction reversals of accepted steps. An accepted step in the same direction as the previous one restarts the count. Lock stays high until reset or load.
- R6: `lock_tmo_o` is high when lock has not been reached within 256 cycles (1024 with jitter reduction) since reset or load.
- R7: Each offset output equals the delay code plus the channel offset, clamped to 0 below and to 63 (low-frequency) or 31 (high-frequency) above. A static channel uses its signed constant in −63..63. A dynamic channel adds its 6-bit magnitude input when its select is 1 and subtracts it when the select is 0.
- R8: While locked, `upd_o` is a one-cycle pulse every 8 cycles, first in the 8th cycle of lock. It is never high while unlocked.
- R9: `held_code_o` takes the delay code at the clock edge where `upd_o` is high, and holds its value otherwise.
- R10: `tap_deg_o` equals 360 divided by the chain length (legal lengths 6, 8, 10, 12, 16).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | Asynchronous restart to the start code |
| ph_up_i | input | 1 | Phase comparator result, 1 = more delay |
| ofs_a_i | input | 6 | Offset magnitude for channel A (dynamic build) |
| ofs_a_add_i | input | 1 | Channel A select, 1 = add, 0 = subtract |
| ofs_b_i | input | 6 | Offset magnitude for channel B (dynamic build) |
| ofs_b_add_i | input | 1 | Channel B select, 1 = add, 0 = subtract |
| dly_code_o | output | 6 | Current delay code |
| ofs_a_code_o | output | 6 | Clamped channel A code |
| ofs_b_code_o | output | 6 | Clamped channel B code |
| lock_o | output | 1 | Loop settled |
| lock_tmo_o | output | 1 | Lock not reached in time |
| upd_o | output | 1 | Update strobe for delay-setting latches |
| held_code_o | output | 6 | Code held by the modelled latches |
| tap_deg_o | output | 8 | Phase of one buffer in degrees |

## Verification
The bench builds two copies of the block side by side. The first uses a 12-buffer chain in low-frequency mode with jitter reduction, a static channel A of −5 and a dynamic channel B. This reaches the 4-sample filter, the 1024-cycle timeout and clamping at 63. The second uses an 8-buffer chain in high-frequency mode without jitter reduction, a dynamic channel A and a static channel B of +40. This reaches the start code of 32 above the 31 ceiling, the 256-cycle timeout and a static offset that always clamps. Long one-way runs drive both codes into the 0 and 63 limits. Reversal patterns matched to each filter length bring lock and the update strobe within reach.

// File: rtl/dlc_pkg.sv
`timescale 1ns/1ps
// Shared widths and mode-derived constants for the DLL delay-code controller.
// Assumes a 6-bit delay code and an 8-bit degree report.
package dlc_pkg;
    localparam int CODE_W = 6;
    localparam int DEG_W  = 8;
    typedef logic [CODE_W-1:0] code_t;

    // Start code after reset or load, chosen by frequency mode.
    function automatic int start_code(input int high_freq);
        return (high_freq != 0) ? 32 : 16;
    endfunction

    // Upper clamp of the offset outputs, chosen by frequency mode.
    function automatic int ceil_code(input int high_freq);
        return (high_freq != 0) ? 31 : 63;
    endfunction
endpackage

// File: rtl/dlc_step_filt.sv
`timescale 1ns/1ps
// Step filter: accepts a step once FILT_LEN consecutive comparator samples
// agree in direction. FILT_LEN = 1 accepts every sample.
// Assumes one comparator sample per clock.
module dlc_step_filt #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic up_i,
    output logic step_o,
    output logic step_up_o
);
    localparam int RUN_W = $clog2(FILT_LEN + 1);

    logic [RUN_W-1:0] run_q;
    logic [RUN_W-1:0] run_nx;
    logic             last_q;
    logic             agree;

    // Next run length: extend on agreement, else start over at one.
    assign agree     = (run_q != '0) && (last_q == up_i);
    assign run_nx    = agree ? run_q + 1'b1 : RUN_W'(1);
    assign step_o    = (run_nx == RUN_W'(FILT_LEN));
    assign step_up_o = up_i;

    // Track run length and last direction; load restarts asynchronously.
    always_ff @(posedge clk or posedge load_i) begin
        if (load_i) begin
            run_q  <= '0;
            last_q <= 1'b0;
        end else if (!rst_n) begin
            run_q  <= '0;
            last_q <= 1'b0;
        end else begin
            run_q  <= step_o ? '0 : run_nx;
            last_q <= up_i;
        end
    end
endmodule

// File: rtl/dlc_lock_trk.sv
`timescale 1ns/1ps
// Lock tracker: counts direction reversals of accepted steps, raises a
// sticky lock after LOCK_RUN of them, and flags a timeout when lock is
// missing after TMO_LIMIT cycles.
module dlc_lock_trk #(
    parameter int LOCK_RUN  = 8,
    parameter int TMO_LIMIT = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic step_i,
    input  logic up_i,
    output logic lock_o,
    output logic tmo_o
);
    localparam int ALT_W = $clog2(LOCK_RUN + 1);
    localparam int TMO_W = $clog2(TMO_LIMIT + 1);

    logic             prev_q;
    logic             have_q;
    logic [ALT_W-1:0] alt_q;
    logic             lock_q;
    logic [TMO_W-1:0] tcnt_q;
    logic             reversal;

    // An accepted step is a reversal when it opposes the previous one.
    assign reversal = have_q && (up_i != prev_q);
    assign lock_o   = lock_q;
    assign tmo_o    = !lock_q && (tcnt_q == TMO_W'(TMO_LIMIT));

    // Reversal counting, sticky lock and timeout counter.
    always_ff @(posedge clk or posedge load_i) begin
        if (load_i) begin
            prev_q <= 1'b0;
            have_q <= 1'b0;
            alt_q  <= '0;
            lock_q <= 1'b0;
            tcnt_q <= '0;
        end else if (!rst_n) begin
            prev_q <= 1'b0;
            have_q <= 1'b0;
            alt_q  <= '0;
            lock_q <= 1'b0;
            tcnt_q <= '0;
        end else begin
            if (step_i) begin
                prev_q <= up_i;
                have_q <= 1'b1;
                if (reversal) begin
                    if (alt_q != ALT_W'(LOCK_RUN)) alt_q <= alt_q + 1'b1;
                    if (alt_q == ALT_W'(LOCK_RUN - 1)) lock_q <= 1'b1;
                end else begin
                    alt_q <= '0;
                end
            end
            if (!lock_q && tcnt_q != TMO_W'(TMO_LIMIT)) tcnt_q <= tcnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/dlc_ofs_chan.sv
`timescale 1ns/1ps
// Offset channel: adds a static signed constant or a dynamic signed
// magnitude to the delay code and clamps the sum to [0, CEIL].
module dlc_ofs_chan
    import dlc_pkg::*;
#(
    parameter int DYN  = 0,
    parameter int SVAL = 0,
    parameter int CEIL = 63
) (
    input  code_t code_i,
    input  code_t mag_i,
    input  logic  add_i,
    output code_t res_o
);
    localparam int SW = CODE_W + 2;
    localparam logic signed [SW-1:0] STAT_S = SW'(SVAL);
    localparam logic signed [SW-1:0] CEIL_S = SW'(CEIL);

    logic signed [SW-1:0] dyn_d;
    logic signed [SW-1:0] delta;
    logic signed [SW-1:0] sum;

    // Pick the offset term, form the sum and clamp it.
    always_comb begin
        dyn_d = add_i ? $signed({2'b00, mag_i}) : -$signed({2'b00, mag_i});
        delta = (DYN != 0) ? dyn_d : STAT_S;
        sum   = $signed({2'b00, code_i}) + delta;
        if (sum < 0)            res_o = '0;
        else if (sum > CEIL_S)  res_o = CEIL_S[CODE_W-1:0];
        else                    res_o = sum[CODE_W-1:0];
    end
endmodule

// File: rtl/dll_code_ctrl.sv
`timescale 1ns/1ps
// DLL delay-code controller top: saturating up/down code driven by a
// filtered phase-comparator stream, lock and timeout tracking, two offset
// channels, periodic update strobe and the modelled delay-setting latches.
// Assumes one comparator decision per reference-clock cycle.
module dll_code_ctrl
    import dlc_pkg::*;
#(
    parameter int CHAIN_LEN  = 12,
    parameter int HIGH_FREQ  = 0,
    parameter int JITTER_RED = 0,
    parameter int OFS_A_DYN  = 0,
    parameter int OFS_A_VAL  = 0,
    parameter int OFS_B_DYN  = 1,
    parameter int OFS_B_VAL  = 0,
    parameter int UPD_PERIOD = 8,
    parameter int LOCK_RUN   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             ph_up_i,
    input  logic [CODE_W-1:0] ofs_a_i,
    input  logic             ofs_a_add_i,
    input  logic [CODE_W-1:0] ofs_b_i,
    input  logic             ofs_b_add_i,
    output logic [CODE_W-1:0] dly_code_o,
    output logic [CODE_W-1:0] ofs_a_code_o,
    output logic [CODE_W-1:0] ofs_b_code_o,
    output logic             lock_o,
    output logic             lock_tmo_o,
    output logic             upd_o,
    output logic [CODE_W-1:0] held_code_o,
    output logic [DEG_W-1:0]  tap_deg_o
);
    localparam int    INIT_CODE = start_code(HIGH_FREQ);
    localparam int    CEIL_CODE = ceil_code(HIGH_FREQ);
    localparam int    FILT_LEN  = (JITTER_RED != 0) ? 4 : 1;
    localparam int    TMO_LIMIT = (JITTER_RED != 0) ? 1024 : 256;
    localparam int    UPD_W     = $clog2(UPD_PERIOD);
    localparam int    TAP_DEG   = 360 / CHAIN_LEN;
    localparam code_t INIT_C    = CODE_W'(INIT_CODE);
    localparam code_t MAX_C     = '1;

    logic              step;
    logic              step_up;
    code_t             code_q;
    logic [UPD_W-1:0]  ucnt_q;
    code_t             held_q;
    code_t [1:0]       mag;
    logic  [1:0]       addsel;
    code_t [1:0]       ofs_res;

    dlc_step_filt #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .up_i(ph_up_i),
        .step_o(step), .step_up_o(step_up)
    );

    dlc_lock_trk #(.LOCK_RUN(LOCK_RUN), .TMO_LIMIT(TMO_LIMIT)) u_lock (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .step_i(step),
        .up_i(step_up), .lock_o(lock_o), .tmo_o(lock_tmo_o)
    );

    // Delay code counter: saturating step, asynchronous load.
    always_ff @(posedge clk or posedge load_i) begin
        if (load_i)      code_q <= INIT_C;
        else if (!rst_n) code_q <= INIT_C;
        else if (step) begin
            if (step_up && code_q != MAX_C)    code_q <= code_q + 1'b1;
            else if (!step_up && code_q != '0) code_q <= code_q - 1'b1;
        end
    end

    // Update strobe phase counter, running only while locked.
    always_ff @(posedge clk) begin
        if (!rst_n || !lock_o)                      ucnt_q <= '0;
        else if (ucnt_q == UPD_W'(UPD_PERIOD - 1))  ucnt_q <= '0;
        else                                        ucnt_q <= ucnt_q + 1'b1;
    end

    assign upd_o = lock_o && (ucnt_q == UPD_W'(UPD_PERIOD - 1));

    // Modelled delay-setting latches: capture on the update strobe only.
    always_ff @(posedge clk) begin
        if (!rst_n)     held_q <= INIT_C;
        else if (upd_o) held_q <= code_q;
    end

    assign mag    = {ofs_b_i, ofs_a_i};
    assign addsel = {ofs_b_add_i, ofs_a_add_i};

    // One offset channel per slot, variant picked by parameters.
    for (genvar ch = 0; ch < 2; ch++) begin : g_ofs
        dlc_ofs_chan #(
            .DYN (ch == 0 ? OFS_A_DYN : OFS_B_DYN),
            .SVAL(ch == 0 ? OFS_A_VAL : OFS_B_VAL),
            .CEIL(CEIL_CODE)
        ) u_chan (
            .code_i(code_q), .mag_i(mag[ch]), .add_i(addsel[ch]),
            .res_o(ofs_res[ch])
        );
    end

    assign dly_code_o   = code_q;
    assign held_code_o  = held_q;
    assign ofs_a_code_o = ofs_res[0];
    assign ofs_b_code_o = ofs_res[1];
    assign tap_deg_o    = DEG_W'(TAP_DEG);
endmodule

// File: rtl/dll_code_ctrl_chk.sv
`timescale 1ns/1ps
// Property checker for dll_code_ctrl, attached by bind.
// Assumes load_i, when used, is seen high at least at one clock edge.
module dll_code_ctrl_chk #(
    parameter int INIT_CODE = 16,
    parameter int CEIL      = 63
) (
    input logic       clk,
    input logic       rst_n,
    input logic       load_i,
    input logic [5:0] dly_code_o,
    input logic [5:0] ofs_a_code_o,
    input logic [5:0] ofs_b_code_o,
    input logic       lock_o,
    input logic       lock_tmo_o,
    input logic       upd_o,
    input logic [5:0] held_code_o
);
    a_r2_load_start: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> (dly_code_o == 6'(INIT_CODE) && !lock_o));

    a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !$past(load_i)) |->
        (dly_code_o == $past(dly_code_o) || dly_code_o == $past(dly_code_o) + 6'd1 ||
         $past(dly_code_o) == dly_code_o + 6'd1));

    a_r5_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        lock_o |=> (lock_o || load_i));

    a_r6_tmo_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        lock_tmo_o |-> !lock_o);

    a_r7_ofs_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        (ofs_a_code_o <= 6'(CEIL)) && (ofs_b_code_o <= 6'(CEIL)));

    a_r8_upd_locked: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |-> lock_o);

    a_r8_upd_single: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |=> !upd_o);

    a_r9_held_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(upd_o) |-> $stable(held_code_o));
endmodule

bind dll_code_ctrl dll_code_ctrl_chk #(.INIT_CODE(INIT_CODE), .CEIL(CEIL_CODE)) u_chk (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .dly_code_o(dly_code_o),
    .ofs_a_code_o(ofs_a_code_o), .ofs_b_code_o(ofs_b_code_o), .lock_o(lock_o),
    .lock_tmo_o(lock_tmo_o), .upd_o(upd_o), .held_code_o(held_code_o)
);

// File: tb/dll_code_ctrl_bench.sv
`timescale 1ns/1ps
// Bench: two builds side by side, random and directed comparator streams,
// every output compared each cycle against a requirement-level model.
module dll_code_ctrl_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic load = 1'b0;
    logic       ph [2];
    logic [5:0] oa [2];
    logic       aa [2];
    logic [5:0] ob [2];
    logic       ab [2];
    logic [5:0] code_w [2];
    logic [5:0] oa_w [2];
    logic [5:0] ob_w [2];
    logic       lock_w [2];
    logic       tmo_w [2];
    logic       upd_w [2];
    logic [5:0] held_w [2];
    logic [7:0] deg_w [2];

    int n_chk = 0;
    int n_bad = 0;
    int acyc = 0;
    bit m_ok = 0;

    // Build settings per copy: jitter, high-freq, A dyn, A val, B dyn, B val.
    int p_jit [2] = '{1, 0};
    int p_hi  [2] = '{0, 1};
    int p_ad  [2] = '{0, 1};
    int p_av  [2] = '{-5, 0};
    int p_bd  [2] = '{1, 0};
    int p_bv  [2] = '{0, 40};

    int m_code [2], m_run [2], m_last [2], m_prev [2], m_hasp [2];
    int m_alt [2], m_lock [2], m_tcnt [2], m_ucnt [2], m_held [2];

    always #2.5 clk = ~clk;

    dll_code_ctrl #(.CHAIN_LEN(12), .HIGH_FREQ(0), .JITTER_RED(1),
        .OFS_A_DYN(0), .OFS_A_VAL(-5), .OFS_B_DYN(1), .OFS_B_VAL(0)) u_dll_code_ctrl (
        .clk(clk), .rst_n(rst_n), .load_i(load), .ph_up_i(ph[0]),
        .ofs_a_i(oa[0]), .ofs_a_add_i(aa[0]), .ofs_b_i(ob[0]), .ofs_b_add_i(ab[0]),
        .dly_code_o(code_w[0]), .ofs_a_code_o(oa_w[0]), .ofs_b_code_o(ob_w[0]),
        .lock_o(lock_w[0]), .lock_tmo_o(tmo_w[0]), .upd_o(upd_w[0]),
        .held_code_o(held_w[0]), .tap_deg_o(deg_w[0]));

    dll_code_ctrl #(.CHAIN_LEN(8), .HIGH_FREQ(1), .JITTER_RED(0),
        .OFS_A_DYN(1), .OFS_A_VAL(0), .OFS_B_DYN(0), .OFS_B_VAL(40)) u_dll_code_ctrl_hf (
        .clk(clk), .rst_n(rst_n), .load_i(load), .ph_up_i(ph[1]),
        .ofs_a_i(oa[1]), .ofs_a_add_i(aa[1]), .ofs_b_i(ob[1]), .ofs_b_add_i(ab[1]),
        .dly_code_o(code_w[1]), .ofs_a_code_o(oa_w[1]), .ofs_b_code_o(ob_w[1]),
        .lock_o(lock_w[1]), .lock_tmo_o(tmo_w[1]), .upd_o(upd_w[1]),
        .held_code_o(held_w[1]), .tap_deg_o(deg_w[1]));

    function automatic int f_init(int i); return p_hi[i] != 0 ? 32 : 16; endfunction
    function automatic int f_ceil(int i); return p_hi[i] != 0 ? 31 : 63; endfunction
    function automatic int f_lim(int i);  return p_jit[i] != 0 ? 1024 : 256; endfunction

    // Expected clamped offset code.
    function automatic int f_ofs(int code, int dyn, int sval, int mag, int add, int ceil);
        int s;
        s = code + ((dyn != 0) ? ((add != 0) ? mag : -mag) : sval);
        if (s < 0) return 0;
        if (s > ceil) return ceil;
        return s;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic m_restart(input int i);
        m_code[i] = f_init(i); m_run[i] = 0; m_last[i] = 0; m_prev[i] = 0;
        m_hasp[i] = 0; m_alt[i] = 0; m_lock[i] = 0; m_tcnt[i] = 0;
    endtask

    // Model of one clock edge for copy i.
    task automatic m_edge(input int i);
        int d, nr, step, flen, upd;
        upd = (m_lock[i] != 0 && m_ucnt[i] == 7) ? 1 : 0;
        if (upd != 0) m_held[i] = m_code[i];
        if (m_lock[i] == 0 && m_tcnt[i] < f_lim(i)) m_tcnt[i]++;
        m_ucnt[i] = (m_lock[i] != 0) ? (m_ucnt[i] + 1) % 8 : 0;
        d = int'(ph[i]);
        flen = (p_jit[i] != 0) ? 4 : 1;
        nr = (m_run[i] != 0 && m_last[i] == d) ? m_run[i] + 1 : 1;
        step = (nr == flen) ? 1 : 0;
        m_run[i] = (step != 0) ? 0 : nr;
        m_last[i] = d;
        if (step != 0) begin
            if (d != 0 && m_code[i] < 63) m_code[i]++;
            else if (d == 0 && m_code[i] > 0) m_code[i]--;
            if (m_hasp[i] != 0 && d != m_prev[i]) begin
                if (m_alt[i] == 7) m_lock[i] = 1;
                if (m_alt[i] < 8) m_alt[i]++;
            end else m_alt[i] = 0;
            m_prev[i] = d;
            m_hasp[i] = 1;
        end
    endtask

    task automatic compare(input int i);
        string s;
        s = $sformatf("inst%0d", i);
        chk({"R3 code ", s}, int'(code_w[i]), m_code[i]);
        chk({"R5 lock ", s}, int'(lock_w[i]), m_lock[i]);
        chk({"R6 timeout ", s}, int'(tmo_w[i]), (m_lock[i] == 0 && m_tcnt[i] >= f_lim(i)) ? 1 : 0);
        chk({"R8 upd ", s}, int'(upd_w[i]), (m_lock[i] != 0 && m_ucnt[i] == 7) ? 1 : 0);
        chk({"R9 held ", s}, int'(held_w[i]), m_held[i]);
        chk({"R7 ofs A ", s}, int'(oa_w[i]),
            f_ofs(m_code[i], p_ad[i], p_av[i], int'(oa[i]), int'(aa[i]), f_ceil(i)));
        chk({"R7 ofs B ", s}, int'(ob_w[i]),
            f_ofs(m_code[i], p_bd[i], p_bv[i], int'(ob[i]), int'(ab[i]), f_ceil(i)));
    endtask

    // One cycle: drive at negedge, compare, then model the coming edge.
    // mode 0 random, 1 up, 2 down, 3 reversal pattern matched to the filter.
    task automatic tick(input int mode, input bit ld, input bit rs);
        @(negedge clk);
        rst_n = !rs;
        load = ld;
        acyc++;
        for (int i = 0; i < 2; i++) begin
            case (mode)
                1: ph[i] = 1'b1;
                2: ph[i] = 1'b0;
                3: ph[i] = (i == 0) ? 1'((acyc / 4) % 2) : 1'(acyc % 2);
                default: ph[i] = 1'($urandom % 2);
            endcase
            oa[i] = 6'($urandom); aa[i] = 1'($urandom);
            ob[i] = 6'($urandom); ab[i] = 1'($urandom);
        end
        #0.5;
        if (ld && m_ok) begin
            for (int i = 0; i < 2; i++) begin
                m_restart(i);
                chk("R2 load code", int'(code_w[i]), f_init(i));
                chk("R2 load lock", int'(lock_w[i]), 0);
            end
        end
        if (m_ok) for (int i = 0; i < 2; i++) compare(i);
        for (int i = 0; i < 2; i++) begin
            if (rs) begin
                m_restart(i); m_ucnt[i] = 0; m_held[i] = f_init(i);
            end else begin
                m_edge(i);
                if (ld) begin m_restart(i); m_ucnt[i] = 0; end
            end
        end
        if (rs) m_ok = 1;
    endtask

    initial begin
        void'($urandom(32'h1d5c0de));
        for (int i = 0; i < 2; i++) begin
            ph[i] = 0; oa[i] = 0; aa[i] = 0; ob[i] = 0; ab[i] = 0;
        end
        repeat (3) tick(1, 0, 1);
        // R1: reset state visible on the first cycle after reset.
        tick(1, 0, 0);
        chk("R1 code inst0", int'(code_w[0]), 16);
        chk("R1 code inst1", int'(code_w[1]), 32);
        chk("R1 held inst1", int'(held_w[1]), 32);
        chk("R1 lock inst0", int'(lock_w[0]), 0);
        chk("R1 upd inst0", int'(upd_w[0]), 0);
        chk("R1 tmo inst1", int'(tmo_w[1]), 0);
        chk("R10 deg inst0", int'(deg_w[0]), 30);
        chk("R10 deg inst1", int'(deg_w[1]), 45);
        // R4: three agreeing samples give no step, the fourth does.
        repeat (3) tick(1, 0, 0);
        chk("R4 no step after 3", int'(code_w[0]), 16);
        chk("R3 every sample steps", int'(code_w[1]), 35);
        tick(1, 0, 0);
        chk("R4 step on 4th", int'(code_w[0]), 17);
        repeat (1100) tick(1, 0, 0);
        chk("R6 timeout jitter build", int'(tmo_w[0]), 1);
        chk("R3 top saturation", int'(code_w[1]), 63);
        repeat (200) tick(3, 0, 0);
        chk("R5 lock inst0", int'(lock_w[0]), 1);
        chk("R5 lock inst1", int'(lock_w[1]), 1);
        repeat (1500) tick(0, 0, 0);
        tick(3, 1, 0);
        repeat (300) tick(2, 0, 0);
        chk("R3 bottom saturation", int'(code_w[0]), 0);
        repeat (200) tick(3, 0, 0);
        repeat (500) tick(0, 0, 0);
        repeat (2) tick(0, 0, 1);
        tick(0, 0, 0);
        chk("R1 code after late reset", int'(code_w[0]), 16);
        chk("R1 lock after late reset", int'(lock_w[1]), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5.0);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: act=%0d exp=%0d", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule